// File: doc/BRIEF.md
# Vertical Blank Flag and Interrupt Generator

This block holds the vertical-blank status flag of a video timing controller and drives the active-low non-maskable interrupt line of a CPU. A frame counter supplies the current scanline and dot. The block sets the flag when vertical blank begins. It clears the flag at the start of the pre-render line, or when the CPU reads status. The interrupt line is the AND of the flag and an enable bit that the CPU writes.

The main job is to settle races at single-clock resolution. These are the races between a status read, the clock that sets the flag, and changes to the enable bit. The outcome decides whether the flag is set in a frame, what a read returns, and whether an interrupt fires. All offsets below count video clocks. The set clock S is the clock in which the counter shows scanline `SET_LINE` and dot `SET_DOT`.

Top module: `vbl_nmi_gen`

## Requirements
- R1: When no read blocks it, the flag rises in clock S. A read in clock S already returns 1. With enable on, `nmi_n` is low from clock S+2 onward.
- R2: A status read (`stat_rd` high for one clock) returns the flag on `rd_flag` in that same clock. It clears the flag from the next clock on, and `nmi_n` returns high at that point.
- R3: A read in clock S-1 returns 0. The flag then stays clear for the rest of that frame, so no interrupt is raised.
- R4: A read in clock S or S+1 returns 1. In that frame `nmi_n` never goes low.
- R5: A read in clock S-2 or S-3 returns 0 and changes nothing. A read in clock S+2 or S+3 returns 1 and the interrupt has already fired.
- R6: Writing enable to 0 (`ctrl_wr` high, `ctrl_nmi_en` low) in clock S-1, S or S+1 prevents the interrupt. The same write in clock S+2, S+3 or S+4 leaves it fired. After any write of 0, `nmi_n` is high from the next clock on.
- R7: Writing enable to 1 while the flag is set drives `nmi_n` low from the next clock on. Toggling enable 0 then 1 within one vertical blank yields a further interrupt.
- R8: In the clock where the counter shows scanline `CLR_LINE`, dot `CLR_DOT`, the flag and any pending block are cleared from the next clock on.
- R9: After reset the flag is 0, enable is 0, `nmi_n` is 1 and `rd_flag` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line | input | LINE_W (9) | Current scanline from the frame counter |
| dot | input | DOT_W (9) | Current dot from the frame counter |
| stat_rd | input | 1 | Status read strobe, one clock per read |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_nmi_en | input | 1 | Enable value written with `ctrl_wr` |
| rd_flag | output | 1 | Flag value returned to a read in the current clock |
| nmi_n | output | 1 | Active-low interrupt request |

## Verification
Two events can land in the same or adjacent clocks: a status read or enable write, and the clock that sets the flag. The bench sweeps each strobe across offsets S-3 to S+4 in one frame window per vector. For each vector it records the value the read returns, whether `nmi_n` went low, and the flag state seen by a final read. A second race puts an enable write on top of an already set flag. There the bench checks that the interrupt appears on the next clock and that a toggle yields another one.

// File: rtl/vbl_nmi_pkg.sv
package vbl_nmi_pkg;

    typedef struct packed {
        logic flag;   // vertical blank status
        logic supp;   // set blocked for this frame
        logic en;     // interrupt enable
        logic nmi;    // interrupt asserted
    } vbl_state_t;

    localparam vbl_state_t VBL_RESET = '{flag: 1'b0, supp: 1'b0, en: 1'b0, nmi: 1'b0};

endpackage

// File: rtl/vbl_pos_match.sv
module vbl_pos_match #(
    parameter int LINE_W = 9,
    parameter int DOT_W  = 9,
    parameter int LINE   = 0,
    parameter int DOT    = 0
) (
    input  logic [LINE_W-1:0] line,
    input  logic [DOT_W-1:0]  dot,
    output logic              hit
);
    localparam logic [LINE_W-1:0] L = LINE_W'(LINE);
    localparam logic [DOT_W-1:0]  D = DOT_W'(DOT);

    assign hit = (line == L) && (dot == D);
endmodule

// File: rtl/vbl_nmi_gen.sv
module vbl_nmi_gen
    import vbl_nmi_pkg::*;
#(
    parameter int LINES    = 262,
    parameter int DOTS     = 341,
    parameter int SET_LINE = 241,
    parameter int SET_DOT  = 1,
    parameter int CLR_LINE = 261,
    parameter int CLR_DOT  = 1,
    parameter int LINE_W   = $clog2(LINES),
    parameter int DOT_W    = $clog2(DOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line,
    input  logic [DOT_W-1:0]  dot,
    input  logic              stat_rd,
    input  logic              ctrl_wr,
    input  logic              ctrl_nmi_en,
    output logic              rd_flag,
    output logic              nmi_n
);
    // Position one clock ahead of the set point (same line, previous dot).
    localparam int PRE_LINE = (SET_DOT > 0) ? SET_LINE : SET_LINE - 1;
    localparam int PRE_DOT  = (SET_DOT > 0) ? SET_DOT - 1 : DOTS - 1;

    logic set_hit, pre_hit, clr_hit;
    logic en_eff;
    vbl_state_t st_d, st_q;

    vbl_pos_match #(.LINE_W(LINE_W), .DOT_W(DOT_W), .LINE(SET_LINE), .DOT(SET_DOT))
        u_set (.line(line), .dot(dot), .hit(set_hit));
    vbl_pos_match #(.LINE_W(LINE_W), .DOT_W(DOT_W), .LINE(PRE_LINE), .DOT(PRE_DOT))
        u_pre (.line(line), .dot(dot), .hit(pre_hit));
    vbl_pos_match #(.LINE_W(LINE_W), .DOT_W(DOT_W), .LINE(CLR_LINE), .DOT(CLR_DOT))
        u_clr (.line(line), .dot(dot), .hit(clr_hit));

    always_comb begin
        st_d   = st_q;
        en_eff = ctrl_wr ? ctrl_nmi_en : st_q.en;
        st_d.en = en_eff;

        // block marker: armed by a read just before the set clock
        if (clr_hit)
            st_d.supp = 1'b0;
        else if (stat_rd && pre_hit)
            st_d.supp = 1'b1;

        // flag: end-of-frame clear and reads win over the set event
        if (clr_hit || stat_rd)
            st_d.flag = 1'b0;
        else if (set_hit && !st_q.supp)
            st_d.flag = 1'b1;

        // interrupt follows registered flag, same-clock enable and clears
        st_d.nmi = st_q.flag && en_eff && !stat_rd && !clr_hit;

        rd_flag = st_q.flag || (set_hit && !st_q.supp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= VBL_RESET;
        else        st_q <= st_d;
    end

    assign nmi_n = ~st_q.nmi;

    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit && !st_q.supp && !stat_rd && !clr_hit) |=> st_q.flag);

    p_rd_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (!st_q.flag && !st_q.nmi));

    p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && pre_hit && !clr_hit) |=> ##1 !st_q.flag);

    p_en_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_nmi_en) |=> nmi_n);

    p_en_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_nmi_en && st_q.flag && !stat_rd && !clr_hit) |=> !nmi_n);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (!st_q.flag && !st_q.supp));

endmodule

// File: tb/vbl_nmi_gen_tb.sv
module vbl_nmi_gen_tb;
    localparam int LW = 9;
    localparam int DW = 9;
    localparam int NV = 15;
    localparam logic [7:0] NO = 8'd100;

    // entry: {read offset, enable-clear offset, exp read value, exp nmi, exp final flag}
    localparam logic [18:0] VEC [NV] = '{
        {8'(-3), NO, 3'b011},  // R5
        {8'(-2), NO, 3'b011},  // R5
        {8'(-1), NO, 3'b000},  // R3
        {8'(0),  NO, 3'b100},  // R4
        {8'(1),  NO, 3'b100},  // R4
        {8'(2),  NO, 3'b110},  // R5
        {8'(3),  NO, 3'b110},  // R5
        {NO, 8'(-1), 3'b001},  // R6
        {NO, 8'(0),  3'b001},  // R6
        {NO, 8'(1),  3'b001},  // R6
        {NO, 8'(2),  3'b011},  // R6
        {NO, 8'(3),  3'b011},  // R6
        {NO, 8'(4),  3'b011},  // R6
        {NO, NO,     3'b011},  // R1
        {NO, NO,     3'b011}   // R1 repeat
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [LW-1:0] line = '0;
    logic [DW-1:0] dot = 9'd5;
    logic stat_rd = 1'b0, ctrl_wr = 1'b0, ctrl_nmi_en = 1'b0;
    logic rd_flag, nmi_n;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vbl_nmi_gen u_dut (
        .clk(clk), .rst_n(rst_n), .line(line), .dot(dot),
        .stat_rd(stat_rd), .ctrl_wr(ctrl_wr), .ctrl_nmi_en(ctrl_nmi_en),
        .rd_flag(rd_flag), .nmi_n(nmi_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // place counter at offset k from the set clock (line 241, dot 1)
    task automatic place(input int k);
        if (1 + k < 0) begin
            line = 9'd240;
            dot  = DW'(341 + 1 + k);
        end else begin
            line = 9'd241;
            dot  = DW'(1 + k);
        end
    endtask

    task automatic step_idle();
        @(posedge clk); #1;
        stat_rd = 0; ctrl_wr = 0; line = 9'd0; dot = 9'd5;
    endtask

    // clear point with enable write: flag and block reset, enable on
    task automatic prep(input bit en);
        @(posedge clk); #1;
        line = 9'd261; dot = 9'd1; stat_rd = 0; ctrl_wr = 1; ctrl_nmi_en = en;
        step_idle();
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(nmi_n === 1'b1, "R9 nmi_n", int'(nmi_n), 1);
        check(rd_flag === 1'b0, "R9 rd_flag", int'(rd_flag), 0);
        @(posedge clk); #1 rst_n = 1;

        // reset leaves enable off: the set clock gives a flag but no interrupt
        begin
            bit seen = 0;
            for (int k = -2; k <= 6; k++) begin
                @(posedge clk); #1; place(k);
                @(negedge clk);
                if (!nmi_n) seen = 1;
            end
            check(!seen, "R9 enable off after reset", int'(seen), 0);
        end

        // vector table sweep
        for (int v = 0; v < NV; v++) begin
            logic signed [7:0] ro, wo;
            bit seen, got_rd, fin;
            ro = $signed(VEC[v][18:11]);
            wo = $signed(VEC[v][10:3]);
            seen = 0; got_rd = 0;
            prep(1'b1);
            for (int k = -4; k <= 12; k++) begin
                @(posedge clk); #1;
                place(k);
                stat_rd = (VEC[v][18:11] != NO) && (int'(ro) == k);
                ctrl_wr = (VEC[v][10:3] != NO) && (int'(wo) == k);
                ctrl_nmi_en = 1'b0;
                @(negedge clk);
                if (stat_rd) got_rd = rd_flag;
                if (!nmi_n) seen = 1;
            end
            @(posedge clk); #1;
            stat_rd = 1; ctrl_wr = 0; line = 9'd0; dot = 9'd5;
            @(negedge clk);
            fin = rd_flag;
            step_idle();
            if (VEC[v][18:11] != NO)
                check(got_rd == VEC[v][2], $sformatf("R2/R3/R4/R5 read value v%0d", v), int'(got_rd), int'(VEC[v][2]));
            check(seen == VEC[v][1], $sformatf("R1/R4/R5/R6 nmi v%0d", v), int'(seen), int'(VEC[v][1]));
            check(fin == VEC[v][0], $sformatf("R2/R3 final flag v%0d", v), int'(fin), int'(VEC[v][0]));
        end

        // R1: exact set timing, nmi low from S+2 not S+1
        prep(1'b1);
        for (int k = -1; k <= 2; k++) begin
            @(posedge clk); #1; place(k);
            @(negedge clk);
            if (k == 1) check(nmi_n === 1'b1, "R1 nmi at S+1", int'(nmi_n), 1);
            if (k == 2) check(nmi_n === 1'b0, "R1 nmi at S+2", int'(nmi_n), 0);
        end
        // R2: read drops the interrupt on the next clock
        @(posedge clk); #1; stat_rd = 1; line = 9'd241; dot = 9'd9;
        @(negedge clk);
        check(rd_flag === 1'b1, "R2 read returns set", int'(rd_flag), 1);
        @(posedge clk); #1; stat_rd = 0;
        @(negedge clk);
        check(nmi_n === 1'b1, "R2 nmi released", int'(nmi_n), 1);
        check(rd_flag === 1'b0, "R2 flag cleared", int'(rd_flag), 0);
        step_idle();

        // R7: enable while flag set, then toggle for a second interrupt
        prep(1'b0);
        for (int k = -1; k <= 3; k++) begin
            @(posedge clk); #1; place(k); ctrl_wr = 0;
        end
        @(posedge clk); #1; line = 9'd241; dot = 9'd10; ctrl_wr = 1; ctrl_nmi_en = 1;
        @(negedge clk);
        check(nmi_n === 1'b1, "R7 not same clock", int'(nmi_n), 1);
        @(posedge clk); #1; ctrl_wr = 0;
        @(negedge clk);
        check(nmi_n === 1'b0, "R7 immediate nmi", int'(nmi_n), 0);
        @(posedge clk); #1; ctrl_wr = 1; ctrl_nmi_en = 0;
        @(posedge clk); #1; ctrl_wr = 0;
        @(negedge clk);
        check(nmi_n === 1'b1, "R6 disable drops nmi", int'(nmi_n), 1);
        @(posedge clk); #1; ctrl_wr = 1; ctrl_nmi_en = 1;
        @(posedge clk); #1; ctrl_wr = 0;
        @(negedge clk);
        check(nmi_n === 1'b0, "R7 second nmi", int'(nmi_n), 0);

        // R8: clear point ends the blank
        @(posedge clk); #1; line = 9'd261; dot = 9'd1;
        @(posedge clk); #1; line = 9'd0; dot = 9'd5;
        @(negedge clk);
        check(nmi_n === 1'b1, "R8 nmi after clear", int'(nmi_n), 1);
        check(rd_flag === 1'b0, "R8 flag after clear", int'(rd_flag), 0);

        // R7: enable while flag clear raises nothing
        @(posedge clk); #1; ctrl_wr = 1; ctrl_nmi_en = 1;
        @(posedge clk); #1; ctrl_wr = 0;
        @(negedge clk);
        check(nmi_n === 1'b1, "R7 enable with flag clear", int'(nmi_n), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule